// File: doc/BRIEF.md
# Host Reset Monitor and Classifier

This block watches the reset indication coming from the host processor and derives two things from it: a one-cycle reset pulse for the on-chip TPM function every time the host enters reset, and a flag that allows the security controller to go into deep sleep once the host has clearly parked itself in a low-power state. A static strap picks which of two reset styles the board uses. In pulse style the host and the controller share one open-drain reset line that the host pulses low on every reboot. In level style the host has a separate platform-reset output that stays low for as long as it is in reset or low power, and the controller has a separate request line into the host.

The monitored line goes through a two-flop synchronizer and a glitch filter. A falling edge of the filtered level becomes the TPM reset pulse. A timer then measures how long the filtered level stays low; it counts ticks from a prescaler, and once the low time is longer than the configured threshold (one second in the default configuration) the deep-sleep flag rises. The flag drops as soon as the filtered level returns high. Short reboot pulses therefore reset the TPM but never permit deep sleep, while a long low level does both. The same timing rule applies in both styles, which covers boards that hold the shared line low during low power.

The block can also reset the host. A one-cycle request starts a fixed-length low drive on the shared line in pulse style, or on the dedicated request line in level style. In pulse style the block masks its own detection while it drives the shared line and for a short tail afterwards, so its own reset is not taken for a host reboot.

Top module: `soc_rst_mon`

## Requirements
- R1: `style_o` has bit 5 set and all other bits clear when `style_level_i` is 0 (pulse style), and bit 6 set and all other bits clear when `style_level_i` is 1 (level style).
- R2: With `style_level_i` at 0 only `sysrst_i` is monitored; with `style_level_i` at 1 only `pltrst_i` is monitored, and activity on the other input changes no output.
- R3: A low level on the monitored input that lasts fewer than FILT_CYC consecutive clock cycles produces no output change; a low level of FILT_CYC cycles or more produces exactly one TPM reset pulse.
- R4: `tpm_rst_o` is high for exactly one clock cycle per accepted falling edge of the monitored level.
- R5: `deep_sleep_ok_o` rises, in either style, when the filtered level has been low for more than TICK_DIV*SLEEP_TICKS cycles; a low input of D cycles makes it rise exactly when D > TICK_DIV*SLEEP_TICKS.
- R6: `deep_sleep_ok_o` is low in every cycle in which the filtered monitored level is high, so it falls in the same cycle the filtered level returns high.
- R7: A one-cycle `host_rst_req_i` while no drive is in progress makes the block drive low for exactly DRIVE_CYC cycles: `sysrst_drive_o` high in pulse style, `hostrst_req_o` high in level style; the output for the other style stays 0.
- R8: In pulse style, the shared line being low because of the block's own drive produces no TPM reset pulse and no deep-sleep permission, up to FILT_CYC+3 cycles after the drive ends; a host pulse after that is detected normally.
- R9: After reset, `tpm_rst_o`, `deep_sleep_ok_o`, `sysrst_drive_o` and `hostrst_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| style_level_i | input | 1 | Strap: 0 pulse style (shared line), 1 level style (separate lines) |
| sysrst_i | input | 1 | Level sensed on the shared open-drain reset line |
| pltrst_i | input | 1 | Platform-reset output of the host, active low |
| host_rst_req_i | input | 1 | One-cycle request to reset the host |
| sysrst_drive_o | output | 1 | Pull-down enable for the shared reset line (1 = pull low) |
| hostrst_req_o | output | 1 | Pull-down enable for the dedicated reset request into the host |
| tpm_rst_o | output | 1 | One-cycle reset pulse for the TPM function |
| deep_sleep_ok_o | output | 1 | Host is in long-term low power; deep sleep is allowed |
| style_o | output | 8 | Reset-style status byte (bit 5 pulse, bit 6 level) |

## Verification
The bench sweeps the low-pulse length across the glitch-filter boundary in both styles, so a filter off by one cycle either passes a pulse one cycle too short or swallows one that is just long enough, and a missing edge detector shows up as more than one TPM pulse per episode. It sweeps the long-low length across the deep-sleep threshold, where a comparison written as "at least" instead of "more than", or a flag not gated by the returning level, changes whether the flag is seen. It issues self-resets in both styles: a missing or too short mask yields a spurious TPM pulse after the block's own drive, and a mask that never ends misses the following genuine host reboot. It also wiggles the unselected input and expects silence.

// File: rtl/rstmon_pkg.sv
package rstmon_pkg;
  typedef enum logic {
    STYLE_PULSE = 1'b0,
    STYLE_LEVEL = 1'b1
  } rst_style_e;

  localparam int unsigned STATUS_W      = 8;
  localparam int unsigned STAT_PULSE_BIT = 5;
  localparam int unsigned STAT_LEVEL_BIT = 6;

  function automatic logic [STATUS_W-1:0] style_status(input rst_style_e s);
    logic [STATUS_W-1:0] v;
    v = '0;
    if (s == STYLE_LEVEL) v[STAT_LEVEL_BIT] = 1'b1;
    else                  v[STAT_PULSE_BIT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rstmon_sync_filt.sv
module rstmon_sync_filt #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic s1_q, s2_q, lvl_q;
  logic [CW-1:0] run_q;

  // two-flop synchronizer, idle high (line released)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // accept a new level only after FILT_CYC equal samples in a row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else if (s2_q == lvl_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      lvl_q <= s2_q;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/rstmon_low_timer.sv
module rstmon_low_timer #(
  parameter int unsigned TICK_DIV    = 24000,
  parameter int unsigned SLEEP_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned PW = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);
  localparam int unsigned TW = $clog2(SLEEP_TICKS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [TW-1:0] TICK_LIM = TW'(SLEEP_TICKS);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] ticks_q;
  logic          tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear_i || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks_q <= '0;
    end else if (clear_i) begin
      ticks_q <= '0;
    end else if (tick && ticks_q != TICK_LIM) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  assign expired_o = (ticks_q == TICK_LIM);
endmodule

// File: rtl/rstmon_host_drive.sv
module rstmon_host_drive #(
  parameter int unsigned DRIVE_CYC = 64,
  parameter int unsigned TAIL_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic busy_o,
  output logic mask_o
);
  localparam int unsigned DW = $clog2(DRIVE_CYC + 1);
  localparam int unsigned TW = $clog2(TAIL_CYC + 1);
  localparam logic [DW-1:0] DRV_LAST = DW'(DRIVE_CYC - 1);
  localparam logic [TW-1:0] TAIL_LEN = TW'(TAIL_CYC);

  logic          busy_q;
  logic [DW-1:0] left_q;
  logic [TW-1:0] tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q <= 1'b1;
        left_q <= DRV_LAST;
      end
    end else if (left_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end

  // keep detection masked while the released line settles through the filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (busy_q) begin
      tail_q <= TAIL_LEN;
    end else if (tail_q != '0) begin
      tail_q <= tail_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign mask_o = busy_q || (tail_q != '0);
endmodule

// File: rtl/soc_rst_mon.sv
module soc_rst_mon #(
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned TICK_DIV    = 24000,
  parameter int unsigned SLEEP_TICKS = 1000,
  parameter int unsigned DRIVE_CYC   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       style_level_i,
  input  logic       sysrst_i,
  input  logic       pltrst_i,
  input  logic       host_rst_req_i,
  output logic       sysrst_drive_o,
  output logic       hostrst_req_o,
  output logic       tpm_rst_o,
  output logic       deep_sleep_ok_o,
  output logic [7:0] style_o
);
  import rstmon_pkg::*;

  localparam int unsigned MASK_TAIL = FILT_CYC + 3;

  rst_style_e style;
  logic       mon_raw;
  logic       line_filt;
  logic       line_prev_q;
  logic       drv_busy;
  logic       drv_mask;
  logic       self_mask;
  logic       tmr_clear;
  logic       tmr_expired;
  logic       tpm_q;

  assign style   = rst_style_e'(style_level_i);
  assign mon_raw = (style == STYLE_LEVEL) ? pltrst_i : sysrst_i;

  rstmon_sync_filt #(
    .FILT_CYC(FILT_CYC)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (mon_raw),
    .level_o(line_filt)
  );

  rstmon_host_drive #(
    .DRIVE_CYC(DRIVE_CYC),
    .TAIL_CYC (MASK_TAIL)
  ) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (host_rst_req_i),
    .busy_o(drv_busy),
    .mask_o(drv_mask)
  );

  // only the shared line loops our own drive back into the monitor
  assign self_mask = drv_mask && (style == STYLE_PULSE);

  assign tmr_clear = line_filt || self_mask;

  rstmon_low_timer #(
    .TICK_DIV   (TICK_DIV),
    .SLEEP_TICKS(SLEEP_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (tmr_clear),
    .expired_o(tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev_q <= 1'b1;
      tpm_q       <= 1'b0;
    end else begin
      line_prev_q <= line_filt;
      tpm_q       <= line_prev_q && !line_filt && !self_mask;
    end
  end

  assign tpm_rst_o       = tpm_q;
  assign deep_sleep_ok_o = tmr_expired && !line_filt && !self_mask;
  assign sysrst_drive_o  = drv_busy && (style == STYLE_PULSE);
  assign hostrst_req_o   = drv_busy && (style == STYLE_LEVEL);
  assign style_o         = style_status(style);
endmodule

// File: rtl/rstmon_chk.sv
module rstmon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       style_level_i,
  input logic       sysrst_drive_o,
  input logic       hostrst_req_o,
  input logic       tpm_rst_o,
  input logic       deep_sleep_ok_o,
  input logic       line_filt,
  input logic       drv_mask
);
  // R4
  tpm_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpm_rst_o |=> !tpm_rst_o);

  // R4
  tpm_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpm_rst_o |-> !$past(line_filt));

  // R6
  sleep_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep_ok_o |-> !line_filt);

  // R5
  sleep_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_sleep_ok_o) |-> !$past(line_filt));

  // R7
  one_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sysrst_drive_o && hostrst_req_o));

  // R7
  shared_drive_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_drive_o |-> !style_level_i);

  // R8
  self_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_mask && !style_level_i) |-> (!tpm_rst_o && !deep_sleep_ok_o));
endmodule

bind soc_rst_mon rstmon_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .style_level_i  (style_level_i),
  .sysrst_drive_o (sysrst_drive_o),
  .hostrst_req_o  (hostrst_req_o),
  .tpm_rst_o      (tpm_rst_o),
  .deep_sleep_ok_o(deep_sleep_ok_o),
  .line_filt      (line_filt),
  .drv_mask       (drv_mask)
);

// File: tb/sim_soc_rst_mon.sv
`timescale 1ns/1ps
module sim_soc_rst_mon;
  localparam int F   = 3;
  localparam int TD  = 4;
  localparam int ST  = 5;
  localparam int DRV = 6;
  localparam int THR = TD * ST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic style_level = 1'b0;
  logic host_sys = 1'b1;
  logic plt = 1'b1;
  logic req = 1'b0;
  logic sys_line;
  logic sysrst_drive, hostrst_req, tpm_rst, ds_ok;
  logic [7:0] style_st;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // open-drain shared line: low if either side pulls
  assign sys_line = host_sys && !sysrst_drive;

  soc_rst_mon #(
    .FILT_CYC(F), .TICK_DIV(TD), .SLEEP_TICKS(ST), .DRIVE_CYC(DRV)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .style_level_i(style_level),
    .sysrst_i(sys_line), .pltrst_i(plt), .host_rst_req_i(req),
    .sysrst_drive_o(sysrst_drive), .hostrst_req_o(hostrst_req),
    .tpm_rst_o(tpm_rst), .deep_sleep_ok_o(ds_ok), .style_o(style_st)
  );

  task automatic check(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst_n = 1'b0;
    style_level = lvl;
    host_sys = 1'b1;
    plt = 1'b1;
    req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // hold the selected line low for len cycles, watch until it settles back
  task automatic episode(input int len, input bit use_plt,
                         output int pulses, output bit ds_seen, output bit ds_end);
    pulses = 0;
    ds_seen = 1'b0;
    @(negedge clk);
    if (use_plt) plt = 1'b0; else host_sys = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pulses += int'(tpm_rst);
      if (ds_ok) ds_seen = 1'b1;
    end
    if (use_plt) plt = 1'b1; else host_sys = 1'b1;
    for (int i = 0; i < F + 6; i++) begin
      @(negedge clk);
      pulses += int'(tpm_rst);
      if (ds_ok) ds_seen = 1'b1;
    end
    ds_end = ds_ok;
  endtask

  task automatic self_reset(output int drv_cyc, output int other_cyc, output int pulses);
    drv_cyc = 0;
    other_cyc = 0;
    pulses = 0;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < DRV + F + 12; i++) begin
      drv_cyc   += style_level ? int'(hostrst_req) : int'(sysrst_drive);
      other_cyc += style_level ? int'(sysrst_drive) : int'(hostrst_req);
      pulses    += int'(tpm_rst);
      if (ds_ok) pulses += 100;
      @(negedge clk);
    end
  endtask

  initial begin
    int p;
    bit s, e;
    int dc, oc;

    // pulse style
    do_reset(1'b0);
    check("R9 tpm_rst after reset", int'(tpm_rst), 0);
    check("R9 deep_sleep after reset", int'(ds_ok), 0);
    check("R9 drives after reset", int'(sysrst_drive) + int'(hostrst_req), 0);
    check("R1 status pulse style", int'(style_st), 32'h20);

    for (int len = 1; len <= F + 3; len++) begin
      episode(len, 1'b0, p, s, e);
      check("R3 R4 pulse-style glitch sweep", p, (len >= F) ? 1 : 0);
    end

    for (int d = THR - 3; d <= THR + 4; d++) begin
      episode(d, 1'b0, p, s, e);
      check("R5 pulse-style sleep threshold", int'(s), (d > THR) ? 1 : 0);
      check("R4 one pulse per long low", p, 1);
      check("R6 sleep flag cleared after release", int'(e), 0);
    end

    // R2: level input ignored in pulse style
    episode(THR + 8, 1'b1, p, s, e);
    check("R2 pltrst ignored in pulse style", p + int'(s), 0);

    // R7 R8: self-issued reset on the shared line
    self_reset(dc, oc, p);
    check("R7 shared drive length", dc, DRV);
    check("R7 no request line in pulse style", oc, 0);
    check("R8 self reset not detected", p, 0);
    episode(F + 1, 1'b0, p, s, e);
    check("R8 host pulse detected after self reset", p, 1);

    // level style
    do_reset(1'b1);
    check("R1 status level style", int'(style_st), 32'h40);
    check("R9 deep_sleep after reset level", int'(ds_ok), 0);

    for (int len = 1; len <= F + 3; len++) begin
      episode(len, 1'b1, p, s, e);
      check("R3 R4 level-style glitch sweep", p, (len >= F) ? 1 : 0);
    end

    for (int d = THR - 1; d <= THR + 2; d++) begin
      episode(d, 1'b1, p, s, e);
      check("R5 level-style sleep threshold", int'(s), (d > THR) ? 1 : 0);
      check("R6 level sleep flag cleared", int'(e), 0);
    end

    // R2: shared line ignored in level style
    episode(THR + 8, 1'b0, p, s, e);
    check("R2 sysrst ignored in level style", p + int'(s), 0);

    // R7: request line in level style
    self_reset(dc, oc, p);
    check("R7 request line length", dc, DRV);
    check("R7 no shared drive in level style", oc, 0);
    check("R7 level request causes no tpm reset", p, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule